// File: doc/BRIEF.md
# Keyed Software Reset Line Controller

This block lets software hold individual peripheral reset lines asserted and then release them, one bit per line. There are two 32-bit registers. The line register carries one reset bit per line. It only accepts a write when the top byte of the write data holds the unlock key. The gate register is an ordinary register with no key. It carries one enable bit per line, and a line's output is driven only while both its gate bit and its line bit are set.

The intended pulse sequence for line n has four writes: set gate bit n, set line bit n with the key, clear line bit n with the key, then clear gate bit n. Each output comes from a flip-flop, so the lines are free of glitches. A build option removes the gate register; each output then follows its line bit directly.

Top module: `swrst_ctrl`

## Requirements
- R1: After reset both registers read as zero and every line output is low.
- R2: A write to offset 0x18 whose data bits [31:24] equal 0x88 loads data bits [NUM_LINES-1:0] into the line register, with bit n belonging to line n.
- R3: A write to offset 0x18 whose bits [31:24] differ from 0x88 leaves the line register unchanged.
- R4: A write to offset 0xFC loads data bits [NUM_LINES-1:0] into the gate register whatever the upper byte holds.
- R5: With the gate register present, output line n is high only while gate bit n and line bit n are both set.
- R6: The line outputs change at the second rising clock edge after a write is presented. At the first edge the registers take the new value, and at the next edge the outputs follow.
- R7: A read of offset 0x18 returns the line bits in [NUM_LINES-1:0], and zero in every other bit, the key byte included.
- R8: A read of offset 0xFC returns the gate bits, bits at or above NUM_LINES are read-only zero, and a read of any other offset returns zero.
- R9: A write to any offset other than 0x18 and 0xFC changes neither register nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data; bits [31:24] carry the key for the line register |
| rdata | output | 32 | Read data for the register at `addr` (combinational) |
| lines_o | output | NUM_LINES | Active-high reset lines to the peripherals |

## Verification
The assertions assume three things about the inputs. First, `wr_en` is driven to a known value every cycle. Second, `addr` and `wdata` are stable while `wr_en` is high. Third, no write arrives while `rst_n` is low, so the first cycle after reset starts from cleared registers. The bench drives every input at the falling clock edge and holds it for a full cycle, and it raises writes only after reset is released. Its random key bytes fall on 0x88 most of the time but also on near misses, and its random offsets mix the two register offsets with unmapped ones.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned KEY_W     = 8;
   localparam int unsigned KEY_LSB   = DATA_W - KEY_W;
   localparam int unsigned MAX_LINES = KEY_LSB;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LINE = 2'd1,
      SEL_GATE = 2'd2
   } reg_sel_e;

   function automatic logic [KEY_W-1:0] key_field(input logic [DATA_W-1:0] d);
      return d[DATA_W-1:KEY_LSB];
   endfunction
endpackage

// File: rtl/swrst_keyed_reg.sv
module swrst_keyed_reg
   import swrst_pkg::*;
#(
   parameter int unsigned NUM_LINES = 24,
   parameter logic [KEY_W-1:0] KEY = 8'h88
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic [DATA_W-1:0]    data_i,
   output logic [NUM_LINES-1:0] bits_o
);
   logic key_ok;
   assign key_ok = (key_field(data_i) == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             bits_o <= '0;
      else if (wr_i && key_ok) bits_o <= data_i[NUM_LINES-1:0];
   end

   assert_key_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && key_field(data_i) == KEY) |=> (bits_o == $past(data_i[NUM_LINES-1:0])));

   assert_key_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && key_field(data_i) != KEY) |=> $stable(bits_o));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(bits_o));
endmodule

// File: rtl/swrst_plain_reg.sv
module swrst_plain_reg
   import swrst_pkg::*;
#(
   parameter int unsigned NUM_LINES = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic [DATA_W-1:0]    data_i,
   output logic [NUM_LINES-1:0] bits_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bits_o <= '0;
      else if (wr_i) bits_o <= data_i[NUM_LINES-1:0];
   end

   assert_gate_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (bits_o == $past(data_i[NUM_LINES-1:0])));

   assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(bits_o));
endmodule

// File: rtl/swrst_line_gate.sv
module swrst_line_gate #(
   parameter int unsigned NUM_LINES = 24,
   parameter bit          USE_GATE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic [NUM_LINES-1:0] gate_i,
   output logic [NUM_LINES-1:0] out_o
);
   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic drive;
      if (USE_GATE) begin : g_gated
         assign drive = line_i[n] & gate_i[n];
      end else begin : g_direct
         assign drive = line_i[n];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_o[n] <= 1'b0;
         else        out_o[n] <= drive;
      end
   end

   assert_out_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_o & ~$past(line_i)) == '0));

   if (USE_GATE) begin : g_gate_chk
      assert_out_needs_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((out_o & ~$past(gate_i)) == '0));
   end

   assert_out_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(line_i) && $stable(gate_i)) |=> $stable(out_o));
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
   import swrst_pkg::*;
#(
   parameter int unsigned      NUM_LINES = 24,
   parameter int unsigned      ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] LINE_OFS = 8'h18,
   parameter logic [ADDR_W-1:0] GATE_OFS = 8'hFC,
   parameter logic [KEY_W-1:0] KEY       = 8'h88,
   parameter bit               HAS_GATE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_LINES-1:0] lines_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_LINES;

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("swrst_ctrl: NUM_LINES out of range");
   end
   if (LINE_OFS == GATE_OFS) begin : g_bad_ofs
      $error("swrst_ctrl: register offsets collide");
   end

   reg_sel_e sel;
   always_comb begin
      if (addr == LINE_OFS)                 sel = SEL_LINE;
      else if (HAS_GATE && addr == GATE_OFS) sel = SEL_GATE;
      else                                  sel = SEL_NONE;
   end

   logic [NUM_LINES-1:0] line_q;
   logic [NUM_LINES-1:0] gate_q;

   swrst_keyed_reg #(.NUM_LINES(NUM_LINES), .KEY(KEY)) u_line (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_en && sel == SEL_LINE),
      .data_i(wdata), .bits_o(line_q)
   );

   if (HAS_GATE) begin : g_gate
      swrst_plain_reg #(.NUM_LINES(NUM_LINES)) u_gate (
         .clk(clk), .rst_n(rst_n),
         .wr_i(wr_en && sel == SEL_GATE),
         .data_i(wdata), .bits_o(gate_q)
      );
   end else begin : g_nogate
      assign gate_q = '1;
   end

   swrst_line_gate #(.NUM_LINES(NUM_LINES), .USE_GATE(HAS_GATE)) u_out (
      .clk(clk), .rst_n(rst_n),
      .line_i(line_q), .gate_i(gate_q), .out_o(lines_o)
   );

   always_comb begin
      unique case (sel)
         SEL_LINE: rdata = {{PAD_W{1'b0}}, line_q};
         SEL_GATE: rdata = {{PAD_W{1'b0}}, gate_q};
         default:  rdata = '0;
      endcase
   end

   assert_rdata_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[DATA_W-1:NUM_LINES] == '0));

   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != LINE_OFS && addr != GATE_OFS) |-> (rdata == '0));
endmodule

// File: tb/tb_swrst_ctrl.sv
module tb_swrst_ctrl;
   localparam int N = 20;
   localparam real HALF = 10.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] lines_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [N-1:0] m_line = '0;
   logic [N-1:0] m_gate = '0;

   always #(HALF) clk = ~clk;

   swrst_ctrl #(.NUM_LINES(N)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .lines_o(lines_o)
   );

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      if (a == 8'h18) return {{(32-N){1'b0}}, m_line};
      if (a == 8'hFC) return {{(32-N){1'b0}}, m_gate};
      return 32'h0;
   endfunction

   function automatic logic [N-1:0] exp_lines();
      return m_line & m_gate;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd_check(input string req, input logic [7:0] a);
      addr = a;
      #1;
      check(req, rdata, exp_read(a));
   endtask

   // write at negedge; registers take it at next posedge, outputs one edge later
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [N-1:0] old;
      old = exp_lines();
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 8'h18 && d[31:24] == 8'h88) m_line = d[N-1:0];
      if (a == 8'hFC) m_gate = d[N-1:0];
      check("R6 outputs lag", {{(32-N){1'b0}}, lines_o}, {{(32-N){1'b0}}, old});
      @(negedge clk);
      check("R5 gated outputs", {{(32-N){1'b0}}, lines_o}, {{(32-N){1'b0}}, exp_lines()});
   endtask

   initial begin
      #(2.0 * HALF * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_check("R1 line reg reset", 8'h18);
      rd_check("R1 gate reg reset", 8'hFC);
      check("R1 outputs reset", {{(32-N){1'b0}}, lines_o}, 32'h0);

      // R3 wrong key rejected
      wr(8'h18, 32'h8700_00FF);
      rd_check("R3 near-miss key", 8'h18);
      wr(8'h18, 32'h0000_0F0F);
      rd_check("R3 zero key", 8'h18);

      // R5 line without gate stays low
      wr(8'h18, 32'h8800_0005);
      rd_check("R2 keyed load", 8'h18);
      check("R5 no gate no output", {{(32-N){1'b0}}, lines_o}, 32'h0);

      // full pulse sequence on line 3
      wr(8'h18, 32'h8800_0000);
      wr(8'hFC, 32'h0000_0008);
      rd_check("R4 gate load", 8'hFC);
      wr(8'h18, 32'h8800_0008);
      check("R5 line 3 asserted", {{(32-N){1'b0}}, lines_o}, 32'h8);
      wr(8'h18, 32'h8800_0000);
      check("R5 line 3 released", {{(32-N){1'b0}}, lines_o}, 32'h0);
      wr(8'hFC, 32'h0000_0000);

      // R4 gate ignores key byte; R8 unused bits read zero
      wr(8'hFC, 32'h12FF_FFFF);
      rd_check("R8 gate upper bits zero", 8'hFC);
      wr(8'h18, 32'h88FF_FFFF);
      rd_check("R7 key byte reads zero", 8'h18);

      // R9 unmapped write ignored
      wr(8'h1C, 32'h8800_0000);
      rd_check("R9 line reg untouched", 8'h18);
      rd_check("R9 gate reg untouched", 8'hFC);
      rd_check("R8 unmapped read zero", 8'h1C);

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int unsigned pick;
         pick = $urandom % 8;
         a = (pick < 3) ? 8'h18 : (pick < 6) ? 8'hFC : 8'($urandom);
         d = $urandom;
         if ($urandom % 4 != 0) d[31:24] = 8'h88;
         else if ($urandom % 2) d[31:24] = 8'h88 ^ (8'h1 << ($urandom % 8));
         wr(a, d);
         rd_check("R2 R3 random line readback", 8'h18);
         rd_check("R4 R8 random gate readback", 8'hFC);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule